// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Refresh

This block is a watchdog for a system-on-chip. Once software enables it, an internal counter advances on ticks from a selectable counting source. If software does not restart the counter before it reaches a programmed limit, the block requests a system reset. It can optionally raise an interrupt first, so that software can save diagnostics before the reset.

The counter restarts only when a fixed pair of 16-bit key words is written to the key register, with the second word arriving soon after the first. A malformed or late pair is treated as runaway software and requests a reset. An optional window mode also faults a refresh that arrives while the count is still below a programmed lower bound, which catches code that runs faster than expected.

Register writes use a plain strobe. A write is accepted in the cycle that `wr_en` is high, so there is no back-pressure and no ready signal. The counting sources are modelled as one-cycle tick enables that are synchronous to the bus clock. A sticky flag records that the watchdog caused the last reset. This flag survives the system reset and is cleared only by the power-on reset.

Top module: `keyed_window_watchdog`

## Requirements
- R1: After a power-on reset, the irq and reset-request outputs and the watchdog-reset flag are 0, and the watchdog is disabled. Register map by `wr_addr`: 0 = key, 1 = config, 2 = timeout limit, 3 = window bound. Config bits: [0] enable, [1] irq enable, [2] window enable, [3] divide-by-256, [5:4] source, [6] run in wait, [7] run in stop, [8] run in debug.
- R2: While enable is 0, the counter stays at zero. No reset or irq is requested, and key writes, including a first key followed by a wrong word, have no effect.
- R3: With the bus clock source (code 0), no prescaler and timeout limit T, enabling the watchdog or refreshing it clears the count. The reset request then rises T+1 cycles after the clock edge that took that write.
- R4: Source code 1, 2 and 3 select `tick_lf`, `tick_mf` and `tick_ext` respectively. Only ticks of the selected source advance the count. With limit T, the reset request rises one cycle after the edge that takes the T-th selected tick.
- R5: With divide-by-256 set, each count step needs 256 source ticks. On the bus clock with limit T, the reset request rises 256*T+1 cycles after enable.
- R6: Writing 0x02A6 and then 0x80B4 to the key register, with the second write landing 1 to 16 cycles after the first, restarts the count. A lone 0x80B4 does not restart it.
- R7: After 0x02A6, a key write of any word other than 0x80B4 requests a reset in the edge that takes it. If no second word arrives, a reset is requested 16 cycles after the first word.
- R8: With window enable set and window bound W, a valid key pair whose second write is taken while the count is below W requests a reset in that same edge. At or above W, it restarts normally.
- R9: With irq enable set, a timeout raises irq T+1 cycles after enable, with no reset at that point. The reset request follows exactly 128 cycles after irq rises.
- R10: While `mode_wait`, `mode_stop` or `mode_debug` is high and the matching run bit is 0, the count and the prescaler hold. When the matching run bit is 1, counting goes on.
- R11: The watchdog-reset flag becomes 1 one cycle after a reset request. It stays 1 through `rst_n` and is cleared only by `por_n`.
- R12: Once raised, the reset request and irq stay high until `rst_n` or `por_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the flag |
| rst_n | input | 1 | System reset, active low; clears all but the flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| tick_lf | input | 1 | Tick enable of the 1 kHz internal source |
| tick_mf | input | 1 | Tick enable of the 32 kHz internal source |
| tick_ext | input | 1 | Tick enable of the external source |
| mode_wait | input | 1 | Chip is in wait mode |
| mode_stop | input | 1 | Chip is in stop mode |
| mode_debug | input | 1 | Chip is halted for debug |
| irq_o | output | 1 | Timeout interrupt request |
| rst_req_o | output | 1 | Reset request to the reset controller |
| wdog_rst_flag_o | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
The timeout path is swept over a run of limits, each with its own arithmetic expectation. Further sweeps run on each clock source and on the prescaler, so that an off-by-one in the compare, a wrong source mux or a wrong divide ratio each gives a distinct cycle count. The key pair is tried at every gap from 1 to 16 cycles, with a wrong second word, with a missing second word and with a lone second word, which separates the gap limit from the word compare. The window bound is crossed by sweeping the refresh point through it. The irq-to-reset delay is measured to the cycle, and each low-power mode is tried with its run bit both clear and set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int WDT_ADDR_W = 2;

  typedef enum logic [WDT_ADDR_W-1:0] {
    A_KEY  = 2'd0,
    A_CFG  = 2'd1,
    A_TOUT = 2'd2,
    A_WIN  = 2'd3
  } wdt_addr_e;

  typedef enum logic [1:0] {
    SRC_BUS = 2'd0,
    SRC_LF  = 2'd1,
    SRC_MF  = 2'd2,
    SRC_EXT = 2'd3
  } wdt_src_e;

  typedef struct packed {
    logic     run_dbg;
    logic     run_stop;
    logic     run_wait;
    wdt_src_e src;
    logic     pre;
    logic     win;
    logic     irq;
    logic     en;
  } wdt_cfg_t;

  localparam int WDT_CFG_W = $bits(wdt_cfg_t);

  typedef enum logic {
    KS_IDLE,
    KS_ARMED
  } wdt_key_state_e;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     run,
  input  wdt_src_e src,
  input  logic     pre,
  input  logic     clear,
  input  logic     tick_lf,
  input  logic     tick_mf,
  input  logic     tick_ext,
  output logic     cnt_tick
);

  logic             src_tick;
  logic [PRE_W-1:0] pc_q;
  logic             pre_wrap;

  always_comb begin
    case (src)
      SRC_BUS: src_tick = 1'b1;
      SRC_LF:  src_tick = tick_lf;
      SRC_MF:  src_tick = tick_mf;
      default: src_tick = tick_ext;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (!en || clear) begin
      pc_q <= '0;
    end else if (run && src_tick) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  assign pre_wrap = (pc_q == {PRE_W{1'b1}});
  assign cnt_tick = en && run && src_tick && (!pre || pre_wrap);

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int          DW     = 16,
  parameter logic [15:0] KEY_A  = 16'h02A6,
  parameter logic [15:0] KEY_B  = 16'h80B4,
  parameter int          LIMIT  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  output logic          refresh_ok,
  output logic          key_fault
);

  localparam int AGE_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(LIMIT - 1);

  wdt_key_state_e   st_q;
  logic [AGE_W-1:0] age_q;
  logic             armed;
  logic             is_a;
  logic             is_b;

  assign armed = en && (st_q == KS_ARMED);
  assign is_a  = (key_data == DW'(KEY_A));
  assign is_b  = (key_data == DW'(KEY_B));

  assign refresh_ok = armed && key_wr && is_b;
  assign key_fault  = armed && ((key_wr && !is_b) || (!key_wr && age_q == AGE_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      age_q <= '0;
    end else if (!en) begin
      st_q  <= KS_IDLE;
      age_q <= '0;
    end else begin
      case (st_q)
        KS_IDLE: begin
          if (key_wr && is_a) begin
            st_q  <= KS_ARMED;
            age_q <= '0;
          end
        end
        default: begin
          if (key_wr || age_q == AGE_LAST) begin
            st_q  <= KS_IDLE;
            age_q <= '0;
          end else begin
            age_q <= age_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/wdt_timeout_ctl.sv
module wdt_timeout_ctl #(
  parameter int DW        = 16,
  parameter int IRQ_DELAY = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          irq_en,
  input  logic          win_en,
  input  logic [DW-1:0] tout,
  input  logic [DW-1:0] win,
  input  logic          cnt_tick,
  input  logic          refresh_ok,
  input  logic          key_fault,
  output logic          irq,
  output logic          rst_req,
  output logic [DW-1:0] cnt
);

  localparam int DLW = (IRQ_DELAY > 1) ? $clog2(IRQ_DELAY) : 1;
  localparam logic [DLW-1:0] DLY_LAST = DLW'(IRQ_DELAY - 1);

  logic [DW-1:0]  cnt_q;
  logic [DLW-1:0] dly_q;
  logic           irq_q;
  logic           rst_q;
  logic           expired;
  logic           early;
  logic           grace_done;
  logic           fault_now;

  assign expired    = en && (cnt_q >= tout) && !irq_q && !rst_q;
  assign early      = win_en && refresh_ok && (cnt_q < win);
  assign grace_done = irq_q && (dly_q == DLY_LAST);
  assign fault_now  = key_fault || early || (expired && !irq_en) || grace_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en || refresh_ok) begin
      cnt_q <= '0;
    end else if (cnt_tick && (cnt_q < tout)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      dly_q <= '0;
      rst_q <= 1'b0;
    end else begin
      if (expired && irq_en) begin
        irq_q <= 1'b1;
      end
      if (irq_q && !rst_q) begin
        dly_q <= dly_q + 1'b1;
      end
      if (fault_now) begin
        rst_q <= 1'b1;
      end
    end
  end

  assign irq     = irq_q;
  assign rst_req = rst_q;
  assign cnt     = cnt_q;

endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog
  import wdt_pkg::*;
#(
  parameter int          DW        = 16,
  parameter logic [15:0] KEY_A     = 16'h02A6,
  parameter logic [15:0] KEY_B     = 16'h80B4,
  parameter int          KEY_LIMIT = 16,
  parameter int          IRQ_DELAY = 128,
  parameter int          PRE_W     = 8
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WDT_ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic                  tick_lf,
  input  logic                  tick_mf,
  input  logic                  tick_ext,
  input  logic                  mode_wait,
  input  logic                  mode_stop,
  input  logic                  mode_debug,
  output logic                  irq_o,
  output logic                  rst_req_o,
  output logic                  wdog_rst_flag_o
);

  logic          sys_rst_n;
  wdt_cfg_t      cfg_q;
  logic [DW-1:0] tout_q;
  logic [DW-1:0] win_q;
  logic          cfg_en_w;
  logic          run_w;
  logic          key_wr_w;
  logic          cnt_tick_w;
  logic          refresh_w;
  logic          key_fault_w;
  logic [DW-1:0] cnt_w;
  logic          flag_q;

  assign sys_rst_n = rst_n & por_n;
  assign cfg_en_w  = cfg_q.en;
  assign key_wr_w  = wr_en && (wr_addr == A_KEY);

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      cfg_q  <= '0;
      tout_q <= '1;
      win_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CFG:   cfg_q  <= wdt_cfg_t'(wr_data[WDT_CFG_W-1:0]);
        A_TOUT:  tout_q <= wr_data;
        A_WIN:   win_q  <= wr_data;
        default: ;
      endcase
    end
  end

  assign run_w = !(mode_wait  && !cfg_q.run_wait) &&
                 !(mode_stop  && !cfg_q.run_stop) &&
                 !(mode_debug && !cfg_q.run_dbg);

  wdt_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .en       (cfg_q.en),
    .run      (run_w),
    .src      (cfg_q.src),
    .pre      (cfg_q.pre),
    .clear    (refresh_w),
    .tick_lf  (tick_lf),
    .tick_mf  (tick_mf),
    .tick_ext (tick_ext),
    .cnt_tick (cnt_tick_w)
  );

  wdt_key_seq #(
    .DW    (DW),
    .KEY_A (KEY_A),
    .KEY_B (KEY_B),
    .LIMIT (KEY_LIMIT)
  ) u_key (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .en         (cfg_q.en),
    .key_wr     (key_wr_w),
    .key_data   (wr_data),
    .refresh_ok (refresh_w),
    .key_fault  (key_fault_w)
  );

  wdt_timeout_ctl #(
    .DW        (DW),
    .IRQ_DELAY (IRQ_DELAY)
  ) u_tmo (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .en         (cfg_q.en),
    .irq_en     (cfg_q.irq),
    .win_en     (cfg_q.win),
    .tout       (tout_q),
    .win        (win_q),
    .cnt_tick   (cnt_tick_w),
    .refresh_ok (refresh_w),
    .key_fault  (key_fault_w),
    .irq        (irq_o),
    .rst_req    (rst_req_o),
    .cnt        (cnt_w)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_q <= 1'b0;
    end else if (rst_req_o) begin
      flag_q <= 1'b1;
    end
  end

  assign wdog_rst_flag_o = flag_q;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int DW        = 16,
  parameter int IRQ_DELAY = 128
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          irq,
  input logic          rst_req,
  input logic          flag,
  input logic [DW-1:0] cnt
);

  localparam int CW = $clog2(IRQ_DELAY) + 2;

  logic [CW-1:0] since_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_irq <= '0;
    end else if (!irq) begin
      since_irq <= '0;
    end else if (since_irq != {CW{1'b1}}) begin
      since_irq <= since_irq + 1'b1;
    end
  end

  // R12
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    flag |=> flag);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !irq && !rst_req) |=> (!irq && !rst_req));

  // R2
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (cfg_en || cnt == '0));

  // R9
  grace_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && since_irq == CW'(IRQ_DELAY)) |-> rst_req);

endmodule

bind keyed_window_watchdog wdt_chk #(
  .DW        (DW),
  .IRQ_DELAY (IRQ_DELAY)
) u_wdt_chk (
  .clk     (clk),
  .por_n   (por_n),
  .rst_n   (sys_rst_n),
  .cfg_en  (cfg_en_w),
  .irq     (irq_o),
  .rst_req (rst_req_o),
  .flag    (wdog_rst_flag_o),
  .cnt     (cnt_w)
);

// File: tb/test_keyed_window_watchdog.sv
`timescale 1ns/1ps
module test_keyed_window_watchdog;

  localparam logic [15:0] KA = 16'h02A6;
  localparam logic [15:0] KB = 16'h80B4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick_lf = 1'b0, tick_mf = 1'b0, tick_ext = 1'b0;
  logic        mode_wait = 1'b0, mode_stop = 1'b0, mode_debug = 1'b0;
  logic        irq_o, rst_req_o, wdog_rst_flag_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  keyed_window_watchdog i_keyed_window_watchdog (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_lf(tick_lf), .tick_mf(tick_mf), .tick_ext(tick_ext),
    .mode_wait(mode_wait), .mode_stop(mode_stop), .mode_debug(mode_debug),
    .irq_o(irq_o), .rst_req_o(rst_req_o), .wdog_rst_flag_o(wdog_rst_flag_o)
  );

  function automatic logic [15:0] cfgw(input bit en, input bit irq, input bit win,
      input bit pre, input logic [1:0] src, input bit rw, input bit rs, input bit rd);
    return {7'b0, rd, rs, rw, src, pre, win, irq, en};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic sysrst();
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic pulse(input int s);
    case (s)
      1: tick_lf = 1'b1;
      2: tick_mf = 1'b1;
      default: tick_ext = 1'b1;
    endcase
    @(negedge clk);
    tick_lf = 1'b0; tick_mf = 1'b0; tick_ext = 1'b0;
  endtask

  task automatic wait_out(input int lim, input bit use_irq, output int n);
    n = 0;
    while (!(use_irq ? irq_o : rst_req_o) && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog_timer
    #(500us);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int n;
    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    chk(rst_req_o == 1'b0, "R1 rst_req", rst_req_o, 0);
    chk(wdog_rst_flag_o == 1'b0, "R1 flag", wdog_rst_flag_o, 0);

    // R2 disabled: nothing counts, key writes ignored
    wr(2'd2, 16'd0);
    idle(50);
    chk(rst_req_o == 1'b0 && irq_o == 1'b0, "R2 disabled timeout", rst_req_o, 0);
    wr(2'd0, KA); wr(2'd0, 16'h1111);
    idle(20);
    chk(rst_req_o == 1'b0, "R2 disabled bad key", rst_req_o, 0);

    // R3 timeout sweep on bus clock
    for (int t = 0; t <= 12; t++) begin
      sysrst();
      wr(2'd2, 16'(t));
      wr(2'd1, cfgw(1, 0, 0, 0, 2'd0, 0, 0, 0));
      wait_out(400, 0, n);
      chk(n == t + 1, "R3 timeout cycles", n, t + 1);
      if (t == 5) begin
        idle(10);
        chk(rst_req_o == 1'b1, "R12 rst_req held", rst_req_o, 1);
        chk(wdog_rst_flag_o == 1'b1, "R11 flag set", wdog_rst_flag_o, 1);
        sysrst();
        chk(wdog_rst_flag_o == 1'b1, "R11 flag survives rst_n", wdog_rst_flag_o, 1);
        chk(rst_req_o == 1'b0, "R12 rst_req cleared by rst_n", rst_req_o, 0);
      end
    end

    // R5 prescaler
    for (int t = 1; t <= 2; t++) begin
      sysrst();
      wr(2'd2, 16'(t));
      wr(2'd1, cfgw(1, 0, 0, 1, 2'd0, 0, 0, 0));
      wait_out(2000, 0, n);
      chk(n == 256 * t + 1, "R5 prescaled timeout", n, 256 * t + 1);
    end

    // R4 source select
    for (int s = 1; s <= 3; s++) begin
      sysrst();
      wr(2'd2, 16'd3);
      wr(2'd1, cfgw(1, 0, 0, 0, 2'(s), 0, 0, 0));
      for (int o = 1; o <= 3; o++) if (o != s) repeat (5) pulse(o);
      idle(5);
      chk(rst_req_o == 1'b0, "R4 other sources ignored", rst_req_o, 0);
      repeat (3) pulse(s);
      chk(rst_req_o == 1'b0, "R4 not yet", rst_req_o, 0);
      idle(1);
      chk(rst_req_o == 1'b1, "R4 selected source timeout", rst_req_o, 1);
    end

    // R6 key pair at every legal gap
    for (int d = 1; d <= 16; d++) begin
      sysrst();
      wr(2'd2, 16'd40);
      wr(2'd1, cfgw(1, 0, 0, 0, 2'd0, 0, 0, 0));
      idle(5);
      wr(2'd0, KA);
      idle(d - 1);
      wr(2'd0, KB);
      wait_out(400, 0, n);
      chk(n == 41, "R6 refresh restarts count", n, 41);
    end
    sysrst();
    wr(2'd2, 16'd30);
    wr(2'd1, cfgw(1, 0, 0, 0, 2'd0, 0, 0, 0));
    idle(10);
    wr(2'd0, KB);
    wait_out(400, 0, n);
    chk(n == 20, "R6 lone second word ignored", n, 20);

    // R7 bad second word, missing second word
    sysrst();
    wr(2'd2, 16'd200);
    wr(2'd1, cfgw(1, 0, 0, 0, 2'd0, 0, 0, 0));
    wr(2'd0, KA);
    wr(2'd0, 16'h80B5);
    chk(rst_req_o == 1'b1, "R7 wrong second word", rst_req_o, 1);
    sysrst();
    wr(2'd2, 16'd200);
    wr(2'd1, cfgw(1, 0, 0, 0, 2'd0, 0, 0, 0));
    wr(2'd0, KA);
    wait_out(400, 0, n);
    chk(n == 16, "R7 missing second word", n, 16);

    // R8 window sweep, W = 10
    for (int m = 0; m <= 14; m++) begin
      sysrst();
      wr(2'd2, 16'd60);
      wr(2'd3, 16'd10);
      wr(2'd1, cfgw(1, 0, 1, 0, 2'd0, 0, 0, 0));
      idle(m);
      wr(2'd0, KA);
      wr(2'd0, KB);
      chk(rst_req_o == ((m + 1) < 10), "R8 window early refresh", rst_req_o, int'((m + 1) < 10));
    end
    sysrst();
    wr(2'd2, 16'd60);
    wr(2'd3, 16'd10);
    wr(2'd1, cfgw(1, 0, 0, 0, 2'd0, 0, 0, 0));
    wr(2'd0, KA);
    wr(2'd0, KB);
    chk(rst_req_o == 1'b0, "R8 window off", rst_req_o, 0);

    // R9 irq then reset after 128 cycles
    for (int t = 2; t <= 7; t += 5) begin
      sysrst();
      wr(2'd2, 16'(t));
      wr(2'd1, cfgw(1, 1, 0, 0, 2'd0, 0, 0, 0));
      wait_out(400, 1, n);
      chk(n == t + 1, "R9 irq timing", n, t + 1);
      chk(rst_req_o == 1'b0, "R9 no reset at irq", rst_req_o, 0);
      wait_out(400, 0, n);
      chk(n == 128, "R9 irq to reset delay", n, 128);
      chk(irq_o == 1'b1, "R12 irq held", irq_o, 1);
    end

    // R10 low-power mode gating
    for (int md = 0; md < 3; md++) begin
      for (int al = 0; al < 2; al++) begin
        sysrst();
        mode_wait = (md == 0); mode_stop = (md == 1); mode_debug = (md == 2);
        wr(2'd2, 16'd4);
        wr(2'd1, cfgw(1, 0, 0, 0, 2'd0, (md == 0) && al == 1,
                      (md == 1) && al == 1, (md == 2) && al == 1));
        if (al == 1) begin
          wait_out(400, 0, n);
          chk(n == 5, "R10 run bit set counts", n, 5);
        end else begin
          idle(40);
          chk(rst_req_o == 1'b0, "R10 paused", rst_req_o, 0);
          mode_wait = 1'b0; mode_stop = 1'b0; mode_debug = 1'b0;
          wait_out(400, 0, n);
          chk(n == 5, "R10 resumes", n, 5);
        end
        mode_wait = 1'b0; mode_stop = 1'b0; mode_debug = 1'b0;
      end
    end

    // R11 cleared by power-on reset
    idle(2);
    chk(wdog_rst_flag_o == 1'b1, "R11 flag before por", wdog_rst_flag_o, 1);
    por_n = 1'b0; idle(2); por_n = 1'b1; idle(1);
    chk(wdog_rst_flag_o == 1'b0, "R11 flag cleared by por", wdog_rst_flag_o, 0);
    chk(rst_req_o == 1'b0, "R1 rst_req after por", rst_req_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule